// File: doc/BRIEF.md
# Per-processor interrupt presenter

This block holds the interrupt state of a single processor and drives that processor's interrupt line. A source controller offers it deliveries, each a source ID with a priority. The block keeps at most one pending source. A more favoured delivery preempts the source already pending. Any delivery that loses, whether because it is too weak for the processor or because it is beaten by the pending source, is bounced back to the source controller as a one-cycle reject pulse that carries the source ID. A second priority register drives an inter-processor interrupt, which competes for the same pending slot under a fixed reserved source ID.

The processor side uses a command strobe with four operations: set processor priority, set inter-processor priority, accept, and end-of-interrupt. The accept operation reads the 32-bit status word and acknowledges it. The status word carries the processor priority in bits 31:24 and the pending source ID in bits 23:0. A pending ID of zero means nothing is pending. A lower priority number is more favoured, and 0xFF stands for "nothing" or "fully masked". When the processor lowers its guard with nothing pending, or finishes an interrupt, the block pulses a resend request so that the source controller can offer again any sources it holds back.

Top module: `irq_presenter`

## Requirements
- R1: After reset the processor priority is 0x00, no source is pending, the pending priority and the inter-processor priority are both 0xFF, and every output is low. An accept issued first returns 0x00000000.
- R2: All outputs are registered and change in the cycle after the strobe. A delivery (`dlv_valid` with no command) whose priority is greater than or equal to the processor priority is rejected. The reject carries its own ID, and the pending state is left unchanged.
- R3: A delivery is rejected, with its own ID, when a source is already pending with a priority less than or equal to the delivery's priority.
- R4: A delivery that passes both tests first rejects the source pending, if there is one, giving that source's ID. The new delivery's ID and priority are then latched and `irq_out` is raised.
- R5: Command op 1 (set inter-processor priority) stores `cmd_data[7:0]`. If that value is below the processor priority, and no source is pending with a priority less than or equal to it, then any pending source is rejected, and the ID 2 is latched with that priority and `irq_out` is raised.
- R6: Command op 2 (accept) returns the whole status word on `rsp_word` with `rsp_valid` high, and lowers `irq_out`. The processor priority then becomes the old pending priority, the pending ID becomes zero, and the pending priority becomes 0xFF.
- R7: Command op 0 (set processor priority) with a value in `cmd_data[7:0]` below the current processor priority stores that value. If a source is pending whose priority is greater than or equal to the new value, that source is cleared, `irq_out` drops, and the source is rejected with its ID.
- R8: Command op 0 with a value greater than or equal to the current processor priority stores that value. If nothing is pending it pulses `rsnd_req`, and it also latches the inter-processor interrupt (ID 2) when the inter-processor priority is below the new processor priority.
- R9: Command op 3 (end-of-interrupt) loads the processor priority from `cmd_data[31:24]` and pulses `eoi_valid` with `eoi_id` equal to `cmd_data[23:0]`. If nothing is pending it also performs the resend behaviour of R8 against the new processor priority.
- R10: `irq_out` is high exactly when the pending source ID is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery offered by the source controller |
| dlv_id | input | 24 | Source ID of the delivery (nonzero) |
| dlv_prio | input | 8 | Priority of the delivery |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 2 | 0 set priority, 1 set inter-processor priority, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| rsp_valid | output | 1 | Accept result valid |
| rsp_word | output | 32 | Status word returned by accept |
| rej_valid | output | 1 | Reject pulse to the source controller |
| rej_id | output | 24 | Rejected source ID |
| rsnd_req | output | 1 | Resend-scan request pulse |
| eoi_valid | output | 1 | End-of-interrupt forward pulse |
| eoi_id | output | 24 | Source ID being retired |

## Verification
The pending ID, pending priority and processor priority are not visible directly. A wrong value in any of them shows up within one command: the next accept returns a wrong status word, the next delivery is bounced or taken wrongly, or `irq_out` disagrees with the pending state in the very next cycle. A wrong inter-processor priority stays hidden until a resend or an end-of-interrupt. At that point ID 2 appears, or fails to appear, one cycle after the strobe. Every step of the sequence is therefore compared on all outputs against a model of the requirements, so a fault surfaces at the first command that depends on the corrupted field.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 24;
    localparam int WORD_W = PRIO_W + ID_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef enum logic [1:0] {
        OP_SET_CPPR = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } irqp_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [ID_W-1:0]   xid;
        logic [PRIO_W-1:0] pend;
        logic [PRIO_W-1:0] ipi;
        logic              irq;
        logic              rej_v;
        logic [ID_W-1:0]   rej_id;
        logic              rsnd;
        logic              eoi_v;
        logic [ID_W-1:0]   eoi_id;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_word;
    } irqp_state_t;
endpackage

// File: rtl/irqp_admit.sv
module irqp_admit #(
    parameter int PW = 8,
    parameter int IW = 24
) (
    input  logic [PW-1:0] cppr,
    input  logic [IW-1:0] cur_id,
    input  logic [PW-1:0] cur_prio,
    input  logic [PW-1:0] req_prio,
    output logic          take,
    output logic          bump
);
    logic busy;
    always_comb begin
        busy = (cur_id != '0);
        take = (req_prio < cppr) && !(busy && (cur_prio <= req_prio));
        bump = take && busy;
    end
endmodule

// File: rtl/irqp_cmd_dec.sv
module irqp_cmd_dec
    import irqp_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic [3:0]        hit,
    output logic [PRIO_W-1:0] arg_prio,
    output logic [PRIO_W-1:0] arg_hi,
    output logic [ID_W-1:0]   arg_id
);
    always_comb begin
        hit = '0;
        if (cmd_valid) hit[cmd_op] = 1'b1;
        arg_prio = cmd_data[PRIO_W-1:0];
        arg_hi   = cmd_data[WORD_W-1:ID_W];
        arg_id   = cmd_data[ID_W-1:0];
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
#(
    parameter logic [23:0] IPI_ID = 24'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dlv_valid,
    input  logic [23:0] dlv_id,
    input  logic [7:0]  dlv_prio,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_data,
    output logic        irq_out,
    output logic        rsp_valid,
    output logic [31:0] rsp_word,
    output logic        rej_valid,
    output logic [23:0] rej_id,
    output logic        rsnd_req,
    output logic        eoi_valid,
    output logic [23:0] eoi_id
);
    irqp_state_t s_d, s_q;

    logic [3:0]        hit;
    logic [PRIO_W-1:0] arg_prio, arg_hi;
    logic [ID_W-1:0]   arg_id;

    irqp_cmd_dec u_dec (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .hit(hit), .arg_prio(arg_prio), .arg_hi(arg_hi), .arg_id(arg_id)
    );

    // Effective priorities seen by the inter-processor check after this command
    logic [PRIO_W-1:0] cppr_eff, ipi_eff;
    always_comb begin
        cppr_eff = hit[OP_SET_CPPR] ? arg_prio : (hit[OP_EOI] ? arg_hi : s_q.cppr);
        ipi_eff  = hit[OP_SET_IPI] ? arg_prio : s_q.ipi;
    end

    logic ipi_take, ipi_bump, dlv_take, dlv_bump;

    irqp_admit #(.PW(PRIO_W), .IW(ID_W)) u_ipi_admit (
        .cppr(cppr_eff), .cur_id(s_q.xid), .cur_prio(s_q.pend),
        .req_prio(ipi_eff), .take(ipi_take), .bump(ipi_bump)
    );

    irqp_admit #(.PW(PRIO_W), .IW(ID_W)) u_dlv_admit (
        .cppr(s_q.cppr), .cur_id(s_q.xid), .cur_prio(s_q.pend),
        .req_prio(dlv_prio), .take(dlv_take), .bump(dlv_bump)
    );

    logic pending;
    assign pending = (s_q.xid != '0);

    always_comb begin
        s_d          = s_q;
        s_d.rej_v    = 1'b0;
        s_d.rej_id   = '0;
        s_d.rsnd     = 1'b0;
        s_d.eoi_v    = 1'b0;
        s_d.eoi_id   = '0;
        s_d.rsp_v    = 1'b0;
        s_d.rsp_word = '0;
        if (hit[OP_SET_CPPR]) begin
            s_d.cppr = arg_prio;
            if (arg_prio < s_q.cppr) begin
                if (pending && (arg_prio <= s_q.pend)) begin
                    s_d.xid    = '0;
                    s_d.pend   = PRIO_NONE;
                    s_d.irq    = 1'b0;
                    s_d.rej_v  = 1'b1;
                    s_d.rej_id = s_q.xid;
                end
            end else if (!pending) begin
                s_d.rsnd = 1'b1;
                if (ipi_take) begin
                    s_d.xid  = IPI_ID;
                    s_d.pend = ipi_eff;
                    s_d.irq  = 1'b1;
                end
            end
        end else if (hit[OP_SET_IPI]) begin
            s_d.ipi = arg_prio;
            if (ipi_take) begin
                if (ipi_bump) begin
                    s_d.rej_v  = 1'b1;
                    s_d.rej_id = s_q.xid;
                end
                s_d.xid  = IPI_ID;
                s_d.pend = ipi_eff;
                s_d.irq  = 1'b1;
            end
        end else if (hit[OP_ACCEPT]) begin
            s_d.rsp_v    = 1'b1;
            s_d.rsp_word = {s_q.cppr, s_q.xid};
            s_d.cppr     = s_q.pend;
            s_d.xid      = '0;
            s_d.pend     = PRIO_NONE;
            s_d.irq      = 1'b0;
        end else if (hit[OP_EOI]) begin
            s_d.cppr   = arg_hi;
            s_d.eoi_v  = 1'b1;
            s_d.eoi_id = arg_id;
            if (!pending) begin
                s_d.rsnd = 1'b1;
                if (ipi_take) begin
                    s_d.xid  = IPI_ID;
                    s_d.pend = ipi_eff;
                    s_d.irq  = 1'b1;
                end
            end
        end else if (dlv_valid) begin
            if (dlv_take) begin
                if (dlv_bump) begin
                    s_d.rej_v  = 1'b1;
                    s_d.rej_id = s_q.xid;
                end
                s_d.xid  = dlv_id;
                s_d.pend = dlv_prio;
                s_d.irq  = 1'b1;
            end else begin
                s_d.rej_v  = 1'b1;
                s_d.rej_id = dlv_id;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.pend <= PRIO_NONE;
            s_q.ipi  <= PRIO_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_out   = s_q.irq;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_word  = s_q.rsp_word;
    assign rej_valid = s_q.rej_v;
    assign rej_id    = s_q.rej_id;
    assign rsnd_req  = s_q.rsnd;
    assign eoi_valid = s_q.eoi_v;
    assign eoi_id    = s_q.eoi_id;

    p_irq_tracks_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (s_q.xid != '0));

    p_idle_prio_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.xid == '0) |-> (s_q.pend == PRIO_NONE));

    p_accept_drops_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACCEPT) |=> (rsp_valid && !irq_out));

    p_eoi_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_EOI) |=>
            (eoi_valid && eoi_id == $past(cmd_data[23:0])));

    p_weak_bounced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !cmd_valid && dlv_prio >= s_q.cppr) |=>
            (rej_valid && rej_id == $past(dlv_id) && $stable(irq_out)));
endmodule

// File: tb/irq_presenter_tb_top.sv
module irq_presenter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dlv_valid;
    logic [23:0] dlv_id;
    logic [7:0]  dlv_prio;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_data;
    logic        irq_out, rsp_valid, rej_valid, rsnd_req, eoi_valid;
    logic [31:0] rsp_word;
    logic [23:0] rej_id, eoi_id;

    always #10 clk = ~clk;

    irq_presenter dut_i (
        .clk(clk), .rst_n(rst_n),
        .dlv_valid(dlv_valid), .dlv_id(dlv_id), .dlv_prio(dlv_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_out(irq_out), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .rej_valid(rej_valid), .rej_id(rej_id), .rsnd_req(rsnd_req),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [7:0]  m_cppr, m_pend, m_ipi;
    logic [23:0] m_xid;
    logic [84:0] e_vec;

    function automatic logic [84:0] act_vec();
        return {irq_out, rej_valid, rej_id, rsnd_req, eoi_valid, eoi_id, rsp_valid, rsp_word};
    endfunction

    task automatic check(string tag, logic [84:0] act, logic [84:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model(bit cv, logic [1:0] op, logic [31:0] data,
                         bit dv, logic [23:0] id, logic [7:0] prio);
        logic e_rej = 0, e_rs = 0, e_eoi = 0, e_rsp = 0;
        logic [23:0] e_rid = 0, e_eid = 0;
        logic [31:0] e_word = 0;
        logic [7:0] np;
        if (cv) begin
            case (op)
                2'd0: begin
                    np = data[7:0];
                    if (np < m_cppr) begin
                        if (m_xid != 0 && np <= m_pend) begin
                            e_rej = 1; e_rid = m_xid; m_xid = 0; m_pend = 8'hFF;
                        end
                        m_cppr = np;
                    end else begin
                        m_cppr = np;
                        if (m_xid == 0) begin
                            e_rs = 1;
                            if (m_ipi < m_cppr) begin m_xid = 24'd2; m_pend = m_ipi; end
                        end
                    end
                end
                2'd1: begin
                    m_ipi = data[7:0];
                    if (m_ipi < m_cppr && !(m_xid != 0 && m_pend <= m_ipi)) begin
                        if (m_xid != 0) begin e_rej = 1; e_rid = m_xid; end
                        m_xid = 24'd2; m_pend = m_ipi;
                    end
                end
                2'd2: begin
                    e_rsp = 1; e_word = {m_cppr, m_xid};
                    m_cppr = m_pend; m_xid = 0; m_pend = 8'hFF;
                end
                default: begin
                    m_cppr = data[31:24]; e_eoi = 1; e_eid = data[23:0];
                    if (m_xid == 0) begin
                        e_rs = 1;
                        if (m_ipi < m_cppr) begin m_xid = 24'd2; m_pend = m_ipi; end
                    end
                end
            endcase
        end else if (dv) begin
            if (prio >= m_cppr || (m_xid != 0 && m_pend <= prio)) begin
                e_rej = 1; e_rid = id;
            end else begin
                if (m_xid != 0) begin e_rej = 1; e_rid = m_xid; end
                m_xid = id; m_pend = prio;
            end
        end
        e_vec = {(m_xid != 0), e_rej, e_rid, e_rs, e_eoi, e_eid, e_rsp, e_word};
    endtask

    // called at a falling edge; returns at the next falling edge with outputs compared
    task automatic step(string tag, bit cv, logic [1:0] op, logic [31:0] data,
                        bit dv, logic [23:0] id, logic [7:0] prio);
        cmd_valid = cv; cmd_op = op; cmd_data = data;
        dlv_valid = dv; dlv_id = id; dlv_prio = prio;
        model(cv, op, data, dv, id, prio);
        @(negedge clk);
        cmd_valid = 0; dlv_valid = 0;
        check(tag, act_vec(), e_vec);
    endtask

    task automatic cmd(string tag, logic [1:0] op, logic [31:0] data);
        step(tag, 1, op, data, 0, 0, 0);
    endtask

    task automatic dlv(string tag, logic [23:0] id, logic [7:0] prio);
        step(tag, 0, 0, 0, 1, id, prio);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    logic [7:0] cp_set [4] = '{8'h00, 8'h05, 8'h80, 8'hFF};
    logic [7:0] pr_set [9] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h06, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    logic [31:0] lfsr = 32'h1ACE_B00C;

    initial begin
        rst_n = 0; cmd_valid = 0; dlv_valid = 0;
        cmd_op = 0; cmd_data = 0; dlv_id = 0; dlv_prio = 0;
        m_cppr = 0; m_xid = 0; m_pend = 8'hFF; m_ipi = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: outputs low after reset, accept returns zero
        check("R1 reset outputs", act_vec(), 85'd0);
        cmd("R1 first accept", 2'd2, 0);
        step("R1 idle", 0, 0, 0, 0, 0, 0);

        // Sweep processor priority against delivery priority
        foreach (cp_set[c]) begin
            cmd("R8 set cppr", 2'd0, {24'd0, cp_set[c]});
            foreach (pr_set[p]) begin
                dlv((pr_set[p] >= cp_set[c]) ? "R2 weak delivery" : "R4 taken delivery",
                    24'h100 + pr_set[p], pr_set[p]);
                cmd("R6 accept", 2'd2, 0);
                cmd("R9 eoi", 2'd3, {cp_set[c], 24'h100 + pr_set[p]});
            end
        end

        // Preemption sequence, open processor priority
        cmd("R8 open cppr", 2'd0, 32'hFF);
        dlv("R4 first pending", 24'h0A, 8'h40);
        dlv("R3 equal bounced", 24'h0B, 8'h40);
        dlv("R4 preempt", 24'h0C, 8'h20);
        dlv("R3 weaker bounced", 24'h0D, 8'h30);
        check("R10 line high", {84'd0, irq_out}, 85'd1);
        cmd("R5 ipi preempts", 2'd1, 32'h10);
        cmd("R5 ipi blocked", 2'd1, 32'h50);
        cmd("R7 cppr clears", 2'd0, 32'h08);
        check("R10 line low", {84'd0, irq_out}, 85'd0);
        cmd("R8 resend loads ipi", 2'd0, 32'hFF);
        cmd("R6 accept ipi", 2'd2, 0);
        cmd("R9 eoi resend", 2'd3, {8'hFF, 24'd2});
        cmd("R5 ipi off", 2'd1, 32'hFF);
        cmd("R6 accept again", 2'd2, 0);
        cmd("R9 eoi no ipi", 2'd3, {8'hFF, 24'd2});
        dlv("R4 pending", 24'h33, 8'h60);
        cmd("R7 cppr keeps better", 2'd0, 32'h70);
        cmd("R8 cppr up with pending", 2'd0, 32'h90);
        cmd("R9 eoi while pending", 2'd3, {8'hFF, 24'h55});
        cmd("R6 accept", 2'd2, 0);

        // Pseudo-random walk over all operations
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] kind;
            logic [7:0] pr;
            logic [23:0] sid;
            for (int k = 0; k < 8; k++)
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            kind = lfsr[2:0];
            pr   = (lfsr[6:3] == 4'hF) ? 8'hFF : {1'b0, lfsr[5:3], 4'h0} | {7'd0, lfsr[7]};
            sid  = {16'd0, lfsr[15:8]} | 24'h10;
            case (kind)
                3'd0: cmd(pr < m_cppr ? "R7 rnd cppr" : "R8 rnd cppr", 2'd0, {24'd0, pr});
                3'd1: cmd("R5 rnd ipi", 2'd1, {24'd0, pr});
                3'd2: cmd("R6 rnd accept", 2'd2, 0);
                3'd3: cmd("R9 rnd eoi", 2'd3, {pr, sid});
                default: dlv("R4 rnd delivery", sid, pr);
            endcase
        end
        finish_run();
    end
endmodule